// File: doc/BRIEF.md
# Online Radix-4 Signed-Digit Adder

This block adds two fractional operands that arrive one radix-4 digit per clock cycle, most significant digit first, and returns their sum in the same redundant signed-digit form, also most significant digit first. Every digit lies in {-3..3}. Because the digit set has more values than the radix, no carry ripples across the word. Each cycle the two incoming digits are summed into a small word. A selection step splits that word into a transfer toward the more significant position and an interim sum. The interim sum is held for one cycle and then joined with the transfer from the next position to form an output digit.

A transaction opens with a one-cycle `start` pulse, which clears the held interim sum and loads the count of output digits wanted. Operand digits then follow under `inValid`, and `lastDigit` marks the final pair. The first output digit comes one cycle after the first accepted pair. Once the last pair has been taken, the block drains by itself, feeding zero digits, until the requested count has been emitted. If the count is reached earlier, the block stops and ignores the rest of the operands. A caller can therefore ask for only the one to three leading digits it needs. The result value is the sum of z_i·4^(-i) for i = 0, 1, ..., where z_0 is an integer digit that absorbs the overflow of adding two fractions.

Top module: `sdOnlineAdder`

## Requirements
- R1: After reset `outValid` is low and stays low until a transaction with a nonzero digit count is started.
- R2: Operand and result digits are 3-bit two's complement values in {-3..3}; the code 3'b100 (-4) never appears on `zDigit` while `outValid` is high.
- R3: The online delay is one cycle: the clock edge that accepts the first operand pair also makes `outValid` high with result digit z_0.
- R4: When the digit count N is at least M+1 for an M-digit operand pair, the emitted digits z_0..z_(N-1) satisfy sum z_i·4^(-i) = X + Y exactly, where X = sum x_i·4^(-i) for i = 1..M.
- R5: After a `start` carrying count N, `outValid` is high for exactly N cycles. The block then stays idle and produces nothing more until the next `start`.
- R6: When N is at most M, the block stops after N digits. Their value lies within 4^(-(N-1)) of X + Y, and the operand digits that follow are ignored.
- R7: After the pair marked by `lastDigit`, the block emits the held interim sum with zero transfer without needing `inValid`. Any further digits up to the count N are zero.
- R8: A cycle in which `inValid` is low during operand intake produces no output digit and leaves the held interim sum unchanged.
- R9: `start` aborts any transaction in progress and clears the held interim sum, so the next result depends only on its own operands.
- R10: A `start` with a digit count of zero produces no output digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that opens a transaction |
| inValid | input | 1 | Operand digit pair present this cycle |
| lastDigit | input | 1 | Marks the final operand digit pair |
| xDigit | input | 3 | Operand X digit, two's complement |
| yDigit | input | 3 | Operand Y digit, two's complement |
| numDigits | input | CNT_W | Count of result digits to emit, sampled at `start` |
| outValid | output | 1 | Result digit present on `zDigit` |
| zDigit | output | 3 | Result digit, two's complement in {-3..3} |

## Verification
The operand patterns are chosen to separate the three selection regions. All-positive-three and all-negative-three operands put every position into a nonzero transfer, mixed small digits keep the transfer at zero, and random operands cross between regions from digit to digit. A count one larger than the operand length checks the exact value. A longer count shows the zero tail after the flush. Counts of one to three against long operands check the truncation bound and the ignored tail. Random `inValid` gaps, an abort taken while the held interim sum is nonzero, and a zero count check that stalls, clears and empty transactions change neither the value nor the digit count.

// File: rtl/sdAdderPkg.sv
package sdAdderPkg;

  // radix-4 signed digit, two's complement, legal range -3..3
  localparam int DIGIT_W = 3;
  localparam int RADIX   = 4;

  typedef logic signed [DIGIT_W-1:0] digit_t;

  // transfer toward the more significant position: -1, 0, +1
  typedef logic signed [1:0] xfer_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearRes;  // zero the held interim sum, drop output valid
    logic advance;   // consume the operand digit pair on the ports
    logic flush;     // consume an implied zero pair
  } strobe_t;

endpackage

// File: rtl/sdDigitSelect.sv
module sdDigitSelect
  import sdAdderPkg::*;
(
  input  digit_t xD,
  input  digit_t yD,
  output xfer_t  tOut,
  output digit_t vOut
);

  localparam int SUM_W = DIGIT_W + 1;
  localparam logic signed [SUM_W-1:0] HI_TH = SUM_W'(RADIX - 1);
  localparam logic signed [SUM_W-1:0] LO_TH = -SUM_W'(RADIX - 1);
  localparam logic signed [SUM_W-1:0] RAD   = SUM_W'(RADIX);

  logic signed [SUM_W-1:0] wSum;
  logic signed [SUM_W-1:0] wAdj;

  // carry-save combine of the two digits into one small word
  always_comb begin
    wSum = {xD[DIGIT_W-1], xD} + {yD[DIGIT_W-1], yD};
  end

  // digit selection: split into transfer and interim sum
  always_comb begin
    if (wSum >= HI_TH) begin
      tOut = 2'sd1;
      wAdj = wSum - RAD;
    end else if (wSum <= LO_TH) begin
      tOut = -2'sd1;
      wAdj = wSum + RAD;
    end else begin
      tOut = 2'sd0;
      wAdj = wSum;
    end
    vOut = wAdj[DIGIT_W-1:0];
  end

  // R4: the split must preserve the value of the pair
  always_comb begin
    if (!$isunknown({xD, yD})) begin
      split_value_chk: assert (wSum == ({{(SUM_W-2){tOut[1]}}, tOut} * RAD)
                               + {vOut[DIGIT_W-1], vOut});
    end
  end

endmodule

// File: rtl/sdAdderDatapath.sv
module sdAdderDatapath
  import sdAdderPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  digit_t  xIn,
  input  digit_t  yIn,
  output logic    validOut,
  output digit_t  zOut
);

  digit_t xSel;
  digit_t ySel;
  xfer_t  tCur;
  digit_t vCur;
  digit_t vReg;
  digit_t zReg;
  logic   validReg;
  logic   emit;

  // flush cycles feed an implied zero pair
  always_comb begin
    xSel = strb.advance ? xIn : '0;
    ySel = strb.advance ? yIn : '0;
    emit = strb.advance | strb.flush;
  end

  sdDigitSelect u_sel (
    .xD  (xSel),
    .yD  (ySel),
    .tOut(tCur),
    .vOut(vCur)
  );

  // residual feedback and output digit register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vReg     <= '0;
      zReg     <= '0;
      validReg <= 1'b0;
    end else if (strb.clearRes) begin
      vReg     <= '0;
      validReg <= 1'b0;
    end else if (emit) begin
      zReg     <= vReg + {tCur[1], tCur};
      vReg     <= vCur;
      validReg <= 1'b1;
    end else begin
      validReg <= 1'b0;
    end
  end

  assign validOut = validReg;
  assign zOut     = zReg;

  // R2
  digit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    validReg |-> (zReg != digit_t'(-4)));

  // R4
  resid_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vReg >= -digit_t'(2)) && (vReg <= digit_t'(2)));

  // R7
  flush_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.flush && !strb.clearRes) |=> (validReg && zReg == $past(vReg)));

  // R9
  clear_res_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearRes |=> (vReg == '0 && !validReg));

endmodule

// File: rtl/sdAdderCtrl.sv
module sdAdderCtrl
  import sdAdderPkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             inValid,
  input  logic             lastDigit,
  input  logic [CNT_W-1:0] numDigits,
  output strobe_t          strb
);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCEPT = 2'd1,
    ST_DRAIN  = 2'd2
  } ctrlState_t;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  ctrlState_t       state;
  logic [CNT_W-1:0] remaining;
  logic             emit;

  always_comb begin
    strb.clearRes = start;
    strb.advance  = !start && (state == ST_ACCEPT) && inValid;
    strb.flush    = !start && (state == ST_DRAIN);
    emit          = strb.advance | strb.flush;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
    end else if (start) begin
      remaining <= numDigits;
      state     <= (numDigits == '0) ? ST_IDLE : ST_ACCEPT;
    end else if (emit) begin
      remaining <= remaining - ONE;
      if (remaining == ONE) begin
        state <= ST_IDLE;
      end else if (state == ST_ACCEPT && lastDigit) begin
        state <= ST_DRAIN;
      end
    end
  end

  // R5
  remain_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (remaining != '0));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACCEPT && !inValid && !start) |=> $stable(remaining));

  // R10
  zero_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && numDigits == '0) |=> (state == ST_IDLE));

endmodule

// File: rtl/sdOnlineAdder.sv
module sdOnlineAdder
  import sdAdderPkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             inValid,
  input  logic             lastDigit,
  input  logic [2:0]       xDigit,
  input  logic [2:0]       yDigit,
  input  logic [CNT_W-1:0] numDigits,
  output logic             outValid,
  output logic [2:0]       zDigit
);

  strobe_t strb;
  digit_t  zInt;

  sdAdderCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .inValid  (inValid),
    .lastDigit(lastDigit),
    .numDigits(numDigits),
    .strb     (strb)
  );

  sdAdderDatapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .xIn     (digit_t'(xDigit)),
    .yIn     (digit_t'(yDigit)),
    .validOut(outValid),
    .zOut    (zInt)
  );

  assign zDigit = zInt;

  // R3
  first_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> outValid);

endmodule

// File: tb/sdOnlineAdder_bench.sv
module sdOnlineAdder_bench;

  localparam int CNT_W = 5;
  localparam int SCALE = 16;

  typedef struct {
    longint expv;
    int     m;
    int     n;
  } item_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic             inValid = 1'b0;
  logic             lastDigit = 1'b0;
  logic [2:0]       xDigit = '0;
  logic [2:0]       yDigit = '0;
  logic [CNT_W-1:0] numDigits = '0;
  logic             outValid;
  logic [2:0]       zDigit;

  int     nChecks = 0;
  int     nFails = 0;
  item_t  q[$];
  longint monAcc = 0;
  int     monK = 0;
  int     xs[1:SCALE];
  int     ys[1:SCALE];
  bit     done = 0;

  always #2 clk = ~clk;

  sdOnlineAdder #(.CNT_W(CNT_W)) u_sdOnlineAdder (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .lastDigit(lastDigit), .xDigit(xDigit), .yDigit(yDigit),
    .numDigits(numDigits), .outValid(outValid), .zDigit(zDigit)
  );

  function automatic longint pow4(int e);
    return longint'(1) << (2 * e);
  endfunction

  task automatic check(bit ok, string req, longint act, longint expd);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expd);
    end
  endtask

  // monitor: pops expected items as the result digits arrive
  always @(posedge clk) begin
    #1;
    if (rstN && outValid && !done) begin
      int z;
      z = $signed(zDigit);
      check(z >= -3 && z <= 3, "R2 digit range", z, 0);
      if (q.size() == 0) begin
        check(0, "R5 extra digit", z, 0);
      end else begin
        if (monK > q[0].m) check(z == 0, "R7 zero tail digit", z, 0);
        monAcc += longint'(z) * pow4(SCALE - monK);
        monK++;
        if (monK == q[0].n) begin
          if (q[0].n >= q[0].m + 1) begin
            check(monAcc == q[0].expv, "R4 exact sum", monAcc, q[0].expv);
          end else begin
            longint d;
            d = monAcc - q[0].expv;
            if (d < 0) d = -d;
            check(d <= pow4(SCALE + 1 - q[0].n), "R6 prefix bound",
                  monAcc, q[0].expv);
          end
          void'(q.pop_front());
          monAcc = 0;
          monK = 0;
        end
      end
    end
  end

  // driver: starts a transaction, pushes its expectation, feeds digits
  task automatic runTxn(int m, int n, int stallPct, int abortAfter);
    item_t it;
    int    fed;
    it.expv = 0;
    for (int i = 1; i <= m; i++)
      it.expv += longint'(xs[i] + ys[i]) * pow4(SCALE - i);
    it.m = m;
    it.n = n;
    if (n > 0) q.push_back(it);
    start = 1'b1;
    numDigits = CNT_W'(n);
    inValid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    fed = (abortAfter > 0) ? abortAfter : m;
    for (int i = 1; i <= fed; i++) begin
      while ($urandom_range(0, 99) < stallPct) begin
        inValid = 1'b0;
        @(negedge clk);
        if (i <= n) check(outValid == 1'b0, "R8 stall no output", outValid, 0);
      end
      inValid = 1'b1;
      xDigit = 3'(xs[i]);
      yDigit = 3'(ys[i]);
      lastDigit = (i == m);
      @(negedge clk);
      if (i == 1 && n > 0) check(outValid == 1'b1, "R3 online delay", outValid, 1);
      if (n == 0) check(outValid == 1'b0, "R10 zero count", outValid, 0);
    end
    inValid = 1'b0;
    lastDigit = 1'b0;
    if (abortAfter > 0) begin
      q.delete();
      monAcc = 0;
      monK = 0;
    end else begin
      for (int g = 0; g < 200 && q.size() != 0; g++) @(negedge clk);
      check(q.size() == 0, "R5 digit count", q.size(), 0);
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic fillConst(int m, int a, int b);
    for (int i = 1; i <= m; i++) begin
      xs[i] = a;
      ys[i] = b;
    end
  endtask

  task automatic fillRand(int m);
    for (int i = 1; i <= m; i++) begin
      xs[i] = $urandom_range(0, 6) - 3;
      ys[i] = $urandom_range(0, 6) - 3;
    end
  endtask

  initial begin
    #(4 * 200000);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 reset state", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 idle after reset", outValid, 0);

    // transfers of +1 at every position (R4)
    fillConst(8, 3, 3);
    runTxn(8, 9, 0, 0);
    // transfers of -1 at every position (R4)
    fillConst(8, -3, -3);
    runTxn(8, 9, 0, 0);
    // zero transfers, flush then zero tail (R7)
    fillConst(6, 1, -2);
    runTxn(6, 10, 0, 0);
    // random operands, exact counts, with stalls (R4, R8)
    for (int k = 0; k < 12; k++) begin
      int m;
      m = $urandom_range(1, 14);
      fillRand(m);
      runTxn(m, m + 1, (k % 3) * 25, 0);
    end
    // early termination, tail inputs ignored (R6)
    for (int k = 1; k <= 3; k++) begin
      fillRand(12);
      runTxn(12, k, 10, 0);
    end
    // abort with a nonzero held interim sum, then a fresh sum (R9)
    fillConst(6, 1, 1);
    runTxn(6, 7, 0, 2);
    fillConst(5, 2, -1);
    runTxn(5, 6, 0, 0);
    // zero digit count (R10)
    fillRand(4);
    runTxn(4, 0, 0, 0);
    repeat (4) @(negedge clk);
    check(outValid == 1'b0, "R10 no output", outValid, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule